// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block runs one DRAM access for a CPU bus port. The bus presents an address strobe, a chip select and an access request, all synchronous to the block clock. The block then holds the bank, row and column address. It raises the row strobe of the addressed bank and switches the address multiplexer from row to column. Next it raises the column strobe and an acknowledge. It holds all of these until the request line is seen low.

A configuration bit picks one of two start modes. In latched mode (`cfg_mode` = 0), a strobe seen with chip select at a rising clock edge sets a pending flag. The row strobe is then registered, so it rises at that edge when the controller is free. In strobe mode (`cfg_mode` = 1), a strobe with chip select raises the row strobe combinationally in the same cycle when the controller is free.

Two things make the controller not free: the `busy_in` input (a refresh or another port's access) and an unexpired precharge interval. While it is not free, the access waits in a pending state. The row strobe then rises at the first rising edge that samples the controller free.

The state machine has five states:
- IDLE: no access.
- PEND: an access is waiting.
- ROW: the row strobe is on and the row address is driven.
- COL: the multiplexer has switched to the column address.
- ACT: the column strobe and acknowledge are on.

The transitions are:
- IDLE→ROW: strobe and select, controller free.
- IDLE→PEND: strobe and select, controller not free.
- PEND→ROW: controller sampled free.
- ROW→COL: after MUX_DLY clocks in ROW.
- COL→ACT: after one clock.
- ACT→IDLE: request sampled low; this loads the precharge counter.

Top module: `dram_access_seq`

## Requirements
- R1: After reset, `ras_o`, `cas_o`, `mux_col_o` and `ack_o` are all low.
- R2: In latched mode, a strobe with chip select at a rising edge, controller free, makes the row strobe high from that edge; in the cycle before the edge it is still low. A strobe with chip select low starts no access in either mode.
- R3: In strobe mode, a strobe with chip select while idle and free raises the row strobe combinationally, before the next clock edge.
- R4: While `busy_in` is high, no row strobe rises. Once `busy_in` falls, the row strobe rises at the next rising edge in both modes, never combinationally.
- R5: The multiplexer select goes to column MUX_DLY clocks after the row strobe rises. The column strobe and `ack_o` rise one clock after that.
- R6: While the column strobe is on, each rising edge samples `req`. The edge that samples it low drops the row strobe, column strobe, multiplexer select and acknowledge together. While `req` is high, all of them hold.
- R7: After the row strobe falls, the precharge counter loads PRECH. With a new strobe and select present from the next cycle on, the row strobe stays low for exactly PRECH+1 cycles.
- R8: `dram_addr_o` carries the row while the select is low and the column while it is high. With `cfg_latch_en` = 1, the address is the value present at the last rising edge with the strobe high, and later input changes have no effect. With `cfg_latch_en` = 0, the address follows the inputs.
- R9: `ras_o` is one-hot or zero. Bit i is the row strobe for bank i, where i is the held bank value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | 0 = latched start, 1 = immediate strobe start |
| cfg_latch_en | input | 1 | 1 = hold the address from the strobe |
| strobe | input | 1 | Address strobe / latch enable |
| cs | input | 1 | Chip select |
| req | input | 1 | Access request; low ends the access |
| busy_in | input | 1 | Refresh or other port in progress |
| bank_in | input | BANK_W | Bank address |
| row_in | input | ADDR_W | Row address |
| col_in | input | ADDR_W | Column address |
| ras_o | output | NUM_BANKS | Row strobe per bank, active high |
| cas_o | output | 1 | Column strobe, active high |
| mux_col_o | output | 1 | 1 = column address on the DRAM address bus |
| ack_o | output | 1 | Access acknowledge |
| dram_addr_o | output | ADDR_W | Multiplexed DRAM address |

## Verification
The bench sweeps both start modes over busy windows of zero, one and three cycles and over every bank. For each access it predicts the exact cycle of every strobe edge.

The bench catches these faults:
- A strobe-mode design that raises the row strobe combinationally after a hold-off shows a high strobe one cycle early.
- A latched-mode design that forgets the pending flag never starts.
- A precharge counter off by one changes the measured low time from PRECH+1.
- An address path that ignores the latch enable shows the changed inputs instead of the held row and column, or a different bank bit.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PEND = 3'd1,
        ST_ROW  = 3'd2,
        ST_COL  = 3'd3,
        ST_ACT  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/dram_addr_hold.sv
module dram_addr_hold #(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic              strobe,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [ADDR_W-1:0] row_in,
    input  logic [ADDR_W-1:0] col_in,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] row_o,
    output logic [ADDR_W-1:0] col_o
);

    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] col_q;
    logic              use_held;

    // Registers follow the inputs while the strobe is high, then hold the last value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
        end else if (strobe) begin
            bank_q <= bank_in;
            row_q  <= row_in;
            col_q  <= col_in;
        end
    end

    assign use_held = latch_en && !strobe;

    always_comb begin
        bank_o = use_held ? bank_q : bank_in;
        row_o  = use_held ? row_q  : row_in;
        col_o  = use_held ? col_q  : col_in;
    end

endmodule

// File: rtl/dram_prech_timer.sv
module dram_prech_timer #(
    parameter int PRECH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);

    localparam int PR_W = (PRECH > 0) ? $clog2(PRECH + 1) : 1;

    logic [PR_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= PR_W'(PRECH);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign ready = (left_q == '0);

    AST_PRECH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (PRECH == 0) || !ready); // R7

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int MUX_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic strobe,
    input  logic cs,
    input  logic req,
    input  logic block,
    input  logic prech_ok,
    output logic ras,
    output logic mux_col,
    output logic cas,
    output logic ack,
    output logic access_end
);

    localparam int CNT_W = (MUX_DLY > 1) ? $clog2(MUX_DLY) : 1;

    seq_state_t      st_q;
    seq_state_t      st_nxt;
    logic [CNT_W-1:0] dly_q;
    logic            free;
    logic            start;
    logic            row_done;
    logic            imm_ras;

    assign free     = !block && prech_ok;
    assign start    = strobe && cs;
    assign row_done = (dly_q == CNT_W'(MUX_DLY - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else if (st_q == ST_ROW && !row_done) begin
            dly_q <= dly_q + 1'b1;
        end else begin
            dly_q <= '0;
        end
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (start)    st_nxt = free ? ST_ROW : ST_PEND;
            ST_PEND: if (free)     st_nxt = ST_ROW;
            ST_ROW:  if (row_done) st_nxt = ST_COL;
            ST_COL:                st_nxt = ST_ACT;
            ST_ACT:  if (!req)     st_nxt = ST_IDLE;
            default:               st_nxt = ST_IDLE;
        endcase
    end

    assign imm_ras = mode && (st_q == ST_IDLE) && start && free;

    always_comb begin
        ras        = imm_ras;
        mux_col    = 1'b0;
        cas        = 1'b0;
        ack        = 1'b0;
        access_end = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_PEND: ;
            ST_ROW: ras = 1'b1;
            ST_COL: begin
                ras     = 1'b1;
                mux_col = 1'b1;
            end
            ST_ACT: begin
                ras        = 1'b1;
                mux_col    = 1'b1;
                cas        = 1'b1;
                ack        = 1'b1;
                access_end = !req;
            end
            default: ;
        endcase
    end

    AST_CAS_AFTER_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas) |-> $past(mux_col) && mux_col); // R5
    AST_END_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cas && !req) |=> !cas && !mux_col && !ack); // R6
    AST_HOLD_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cas && req) |=> cas); // R6
    AST_NO_RAS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE || st_q == ST_PEND) && block) |-> !ras); // R4

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
    import dram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 10,
    parameter int MUX_DLY   = 1,
    parameter int PRECH     = 2,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_mode,
    input  logic                 cfg_latch_en,
    input  logic                 strobe,
    input  logic                 cs,
    input  logic                 req,
    input  logic                 busy_in,
    input  logic [BANK_W-1:0]    bank_in,
    input  logic [ADDR_W-1:0]    row_in,
    input  logic [ADDR_W-1:0]    col_in,
    output logic [NUM_BANKS-1:0] ras_o,
    output logic                 cas_o,
    output logic                 mux_col_o,
    output logic                 ack_o,
    output logic [ADDR_W-1:0]    dram_addr_o
);

    logic [BANK_W-1:0] bank_eff;
    logic [ADDR_W-1:0] row_eff;
    logic [ADDR_W-1:0] col_eff;
    logic              ras_any;
    logic              prech_ok;
    logic              access_end;

    dram_addr_hold #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (cfg_latch_en),
        .strobe   (strobe),
        .bank_in  (bank_in),
        .row_in   (row_in),
        .col_in   (col_in),
        .bank_o   (bank_eff),
        .row_o    (row_eff),
        .col_o    (col_eff)
    );

    dram_prech_timer #(
        .PRECH (PRECH)
    ) u_prech (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (access_end),
        .ready (prech_ok)
    );

    dram_seq_fsm #(
        .MUX_DLY (MUX_DLY)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (cfg_mode),
        .strobe     (strobe),
        .cs         (cs),
        .req        (req),
        .block      (busy_in),
        .prech_ok   (prech_ok),
        .ras        (ras_any),
        .mux_col    (mux_col_o),
        .cas        (cas_o),
        .ack        (ack_o),
        .access_end (access_end)
    );

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_ras
        assign ras_o[gi] = ras_any && (bank_eff == BANK_W'(gi));
    end

    assign dram_addr_o = mux_col_o ? col_eff : row_eff;

    AST_RAS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ras_o)); // R9
    AST_RAS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_any) |=> !ras_any); // R7
    AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        cas_o |-> (ras_o != '0)); // R5

endmodule

// File: tb/dram_access_seq_tb.sv
module dram_access_seq_tb;

    localparam int NB = 4;
    localparam int BW = 2;
    localparam int AW = 6;
    localparam int MD = 2;
    localparam int PC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_mode = 1'b0;
    logic          cfg_latch_en = 1'b1;
    logic          strobe = 1'b0;
    logic          cs = 1'b0;
    logic          req = 1'b0;
    logic          busy_in = 1'b0;
    logic [BW-1:0] bank_in = '0;
    logic [AW-1:0] row_in = '0;
    logic [AW-1:0] col_in = '0;
    logic [NB-1:0] ras_o;
    logic          cas_o;
    logic          mux_col_o;
    logic          ack_o;
    logic [AW-1:0] dram_addr_o;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dram_access_seq #(
        .NUM_BANKS (NB),
        .ADDR_W    (AW),
        .MUX_DLY   (MD),
        .PRECH     (PC)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .cfg_latch_en (cfg_latch_en),
        .strobe       (strobe),
        .cs           (cs),
        .req          (req),
        .busy_in      (busy_in),
        .bank_in      (bank_in),
        .row_in       (row_in),
        .col_in       (col_in),
        .ras_o        (ras_o),
        .cas_o        (cas_o),
        .mux_col_o    (mux_col_o),
        .ack_o        (ack_o),
        .dram_addr_o  (dram_addr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_idle();
        for (int k = 0; k < PC + 2; k++) step();
    endtask

    task automatic do_access(input logic mode, input int busy_n, input int hold_n,
                             input int bank, input logic [AW-1:0] row,
                             input logic [AW-1:0] col, input bit b2b);
        logic [NB-1:0] exp_ras;
        int zeros;
        exp_ras = NB'(1) << bank;
        cfg_mode = mode;
        busy_in  = (busy_n > 0);
        strobe   = 1'b1;
        cs       = 1'b1;
        bank_in  = BW'(bank);
        row_in   = row;
        col_in   = col;
        req      = 1'b0;
        #1;
        // R3 comb start in strobe mode only; R2 latched mode waits for the edge
        chk("R3 immediate ras", 32'(ras_o), (mode && busy_n == 0) ? 32'(exp_ras) : 0);
        for (int i = 0; i < busy_n; i++) begin
            step();
            chk("R4 held off", 32'(ras_o), 0);
            if (i == busy_n - 1) busy_in = 1'b0;
            #1;
            chk("R4 no comb start after hold", 32'(ras_o), 0);
        end
        step();
        chk("R2 ras after edge", 32'(ras_o), 32'(exp_ras));
        chk("R5 mux row", 32'(mux_col_o), 0);
        chk("R8 row addr", 32'(dram_addr_o), 32'(row));
        strobe  = 1'b0;
        row_in  = ~row;
        col_in  = ~col;
        bank_in = BW'(bank) ^ 2'b01;
        req     = 1'b1;
        #1;
        chk("R8 row held", 32'(dram_addr_o), 32'(row));
        chk("R9 bank held", 32'(ras_o), 32'(exp_ras));
        for (int j = 1; j < MD; j++) begin
            step();
            chk("R5 mux still row", 32'(mux_col_o), 0);
        end
        step();
        chk("R5 mux col", 32'(mux_col_o), 1);
        chk("R5 cas not yet", 32'(cas_o), 0);
        chk("R8 col addr", 32'(dram_addr_o), 32'(col));
        step();
        chk("R5 cas on", 32'(cas_o), 1);
        chk("R5 ack on", 32'(ack_o), 1);
        chk("R9 ras during cas", 32'(ras_o), 32'(exp_ras));
        for (int h = 0; h < hold_n; h++) begin
            step();
            chk("R6 held by req", 32'(cas_o & ack_o & mux_col_o), 1);
        end
        req = 1'b0;
        step();
        chk("R6 end ras", 32'(ras_o), 0);
        chk("R6 end cas/mux/ack", 32'({cas_o, mux_col_o, ack_o}), 0);
        if (b2b) begin
            cfg_mode = 1'b1;
            strobe   = 1'b1;
            cs       = 1'b1;
            bank_in  = BW'(bank);
            zeros    = 0;
            #1;
            while (ras_o == '0 && zeros < 20) begin
                zeros++;
                step();
            end
            chk("R7 precharge low cycles", 32'(zeros), 32'(PC + 1));
            strobe = 1'b0;
            for (int k = 0; k < MD + 3; k++) step();
            chk("R6 back-to-back access ended", 32'(ras_o), 0);
        end
        settle_idle();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset ras", 32'(ras_o), 0);
        chk("R1 reset cas/mux/ack", 32'({cas_o, mux_col_o, ack_o}), 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", 32'({ras_o, cas_o, mux_col_o, ack_o}), 0);

        // R2 chip select low starts nothing, in both modes
        for (int m = 0; m < 2; m++) begin
            cfg_mode = m[0];
            strobe = 1'b1;
            cs = 1'b0;
            #1;
            chk("R2 no cs no ras", 32'(ras_o), 0);
            step();
            step();
            chk("R2 no cs still idle", 32'(ras_o), 0);
            strobe = 1'b0;
            step();
        end

        // sweep: mode x busy window x hold length, banks rotating
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 3; b++) begin
                for (int h = 0; h < 2; h++) begin
                    do_access(m[0], (b == 2) ? 3 : b, 2 * h, (m * 6 + b * 2 + h) % NB,
                              AW'(5 + 7 * b + h), AW'(40 - 3 * b - m), 1'b0);
                end
            end
        end

        // R7 back-to-back in both modes
        do_access(1'b0, 0, 1, 2, 6'h15, 6'h2a, 1'b1);
        do_access(1'b1, 1, 0, 3, 6'h09, 6'h30, 1'b1);

        // R8 address transparent when latching is off
        cfg_latch_en = 1'b0;
        cfg_mode = 1'b0;
        bank_in = 2'd1;
        row_in = 6'h11;
        col_in = 6'h22;
        strobe = 1'b1;
        cs = 1'b1;
        step();
        strobe = 1'b0;
        row_in = 6'h33;
        #1;
        chk("R8 follows input without latch", 32'(dram_addr_o), 32'h33);
        req = 1'b0;
        for (int k = 0; k < MD + PC + 6; k++) step();
        chk("R6 idle after unlatched access", 32'(ras_o), 0);
        cfg_latch_en = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule